// File: doc/BRIEF.md
# Debug Breakpoint Address Matcher

This block watches the address stream of a processor core and flags accesses that hit one of four programmable breakpoint slots. Each slot holds an address, a 2-bit access-type code and a 2-bit length code. On every cycle the core presents one access descriptor: an address, a byte count from 1 to 8 and a kind (instruction fetch, data read, data write or I/O). The unit reports which armed slots matched and raises a one-cycle debug request. Matching slots also leave sticky detect bits in a status register.

Software programs the unit through a small register port. Four address registers, a status register and a control register are selected by index. The control register carries the per-slot local and global enables, the type and length codes, and a general-detect bit. While general-detect is set, any software access to these registers is blocked. The blocked access is recorded in the status register and turned into a debug request, so that a debugger can guard its own resources. The core can also post single-step and task-switch events into the status register.

Top module: `dbg_bp_matcher`

## Requirements
- R1: Type code 2'b01 matches only data writes (acc_kind 2'b10). Type code 2'b11 matches data reads (acc_kind 2'b01) and data writes. Neither matches a fetch (2'b00) or an I/O access (2'b11).
- R2: Type code 2'b10 matches I/O accesses (acc_kind 2'b11) only while io_ext_en is high. While io_ext_en is low, a slot with this code never matches.
- R3: Length code 2'b00 covers 1 byte, 2'b01 covers 2 bytes, 2'b11 covers 4 bytes and 2'b10 covers 8 bytes. The slot address is aligned down to that size, because the low address bits inside the length are ignored.
- R4: A data or I/O slot matches when any byte of the access [acc_addr, acc_addr+acc_bytes-1] lies inside the slot's aligned byte range. acc_bytes must be 1 to 8.
- R5: Type code 2'b00 matches only an instruction fetch whose acc_addr equals the slot address exactly. The slot's length code and the fetch size are ignored.
- R6: A slot is armed when its local enable (control bit n) or its global enable (control bit 4+n) is set. A disarmed slot never matches.
- R7: hit_vec shows the matching slots of an access in the cycle after it is presented, and for that one cycle only. dbg_req pulses in the same cycle whenever hit_vec is non-zero.
- R8: dbg_req_insn is high together with dbg_req exactly when at least one matching slot has type code 2'b00.
- R9: Status bits 3:0 are sticky per-slot detect bits, and several may be set by one access. Only a status write (reg_sel 4) changes them. A detection in the same cycle as the write is ORed on top of the written value.
- R10: When general-detect (control bit 8) is set, any register read or write is blocked. A blocked read returns zero. The blocked access sets status bit 4, pulses dbg_req in the next cycle and clears general-detect.
- R11: A step_evt pulse sets status bit 5 and a task_evt pulse sets status bit 6. Neither raises dbg_req.
- R12: Reset clears all registers and outputs, so every slot starts disarmed. Register map: reg_sel 0-3 are slot addresses, 4 is status, 5 is control. Control bits 16+2n..17+2n hold slot n's type code and bits 24+2n..25+2n hold its length code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register index |
| reg_wdata | input | ADDR_W | Write data |
| reg_rdata | output | ADDR_W | Read data (combinational, zero when idle or blocked) |
| io_ext_en | input | 1 | Enables the I/O meaning of type code 2'b10 |
| step_evt | input | 1 | Single-step event from the core |
| task_evt | input | 1 | Task-switch event from the core |
| acc_valid | input | 1 | Access descriptor valid |
| acc_addr | input | ADDR_W | Address of the first byte accessed |
| acc_bytes | input | 4 | Number of bytes accessed (1 to 8) |
| acc_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 I/O |
| hit_vec | output | 4 | Matching slots of the previous access |
| dbg_req | output | 1 | One-cycle debug request |
| dbg_req_insn | output | 1 | Request includes an instruction-breakpoint match |

## Verification
The assertions check the following on every cycle:
- Only slots that were armed report a hit.
- An I/O-type slot hits only while the extension input was high.
- Every hit is reflected in the detect bits, and status bits never drop without a status write.
- Every request has a cause, and the instruction qualifier never stands alone.
- A general-detect trap clears the enable and records the access.

Only the bench's scenarios can show that the type, length, alignment and overlap arithmetic picks exactly the right accesses. The same goes for the exact-address rule for fetches and for blocked writes leaving the registers unchanged.

// File: rtl/dbg_bp_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, encodings and helpers for the breakpoint matcher.
// Assumes four slots; the register layout below is derived from SLOTS.
package dbg_bp_pkg;
    localparam int SLOTS       = 4;
    localparam int TYPE_W      = 2;
    localparam int LEN_W       = 2;
    localparam int SEL_W       = 3;
    localparam int NBYTE_W     = 4;
    localparam int CTL_GLB_LO  = SLOTS;
    localparam int CTL_GD_BIT  = 2 * SLOTS;
    localparam int CTL_TYPE_LO = 16;
    localparam int CTL_LEN_LO  = CTL_TYPE_LO + SLOTS * TYPE_W;
    localparam int STS_BD      = SLOTS;
    localparam int STS_BS      = SLOTS + 1;
    localparam int STS_BT      = SLOTS + 2;
    localparam int STS_W       = SLOTS + 3;

    typedef enum logic [TYPE_W-1:0] {
        BPT_EXEC  = 2'b00,
        BPT_WRITE = 2'b01,
        BPT_IO    = 2'b10,
        BPT_RDWR  = 2'b11
    } bp_type_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_IO    = 2'b11
    } acc_kind_e;

    localparam logic [SEL_W-1:0] SEL_STATUS  = 3'd4;
    localparam logic [SEL_W-1:0] SEL_CONTROL = 3'd5;

    // Byte count covered by a length code.
    function automatic logic [NBYTE_W-1:0] len_bytes(input logic [LEN_W-1:0] code);
        case (code)
            2'b00:   len_bytes = 4'd1;
            2'b01:   len_bytes = 4'd2;
            2'b10:   len_bytes = 4'd8;
            default: len_bytes = 4'd4;
        endcase
    endfunction
endpackage

// File: rtl/dbg_bp_slot.sv
`timescale 1ns/1ps
// Module: one breakpoint comparator.
// Decides combinationally whether the current access hits this slot.
// Data and I/O types use aligned range overlap. The execute type uses an exact
// address compare on fetches. Assumes acc_bytes is 1..8.
module dbg_bp_slot
    import dbg_bp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]  bp_addr,
    input  logic [TYPE_W-1:0]  bp_type,
    input  logic [LEN_W-1:0]   bp_len,
    input  logic               armed,
    input  logic               io_ext_en,
    input  logic               acc_valid,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [NBYTE_W-1:0] acc_bytes,
    input  logic [1:0]         acc_kind,
    output logic               hit
);
    localparam int EW = ADDR_W + 1;

    logic [NBYTE_W-1:0] span;
    logic [ADDR_W-1:0]  low_mask;
    logic [ADDR_W-1:0]  base;
    logic [EW-1:0]      rng_first;
    logic [EW-1:0]      rng_last;
    logic [EW-1:0]      acc_first;
    logic [EW-1:0]      acc_last;
    logic               overlap;
    logic               type_hit;

    // Aligned slot range and access range, one bit wider to avoid wrap.
    always_comb begin
        span      = len_bytes(bp_len);
        low_mask  = ADDR_W'(span - 4'd1);
        base      = bp_addr & ~low_mask;
        rng_first = {1'b0, base};
        rng_last  = rng_first + EW'(span - 4'd1);
        acc_first = {1'b0, acc_addr};
        acc_last  = acc_first + EW'(acc_bytes - 4'd1);
        overlap   = (acc_first <= rng_last) && (acc_last >= rng_first);
    end

    // Kind filter per type code.
    always_comb begin
        case (bp_type_e'(bp_type))
            BPT_EXEC:  type_hit = (acc_kind == ACC_FETCH) && (acc_addr == bp_addr);
            BPT_WRITE: type_hit = (acc_kind == ACC_WRITE) && overlap;
            BPT_IO:    type_hit = io_ext_en && (acc_kind == ACC_IO) && overlap;
            default:   type_hit = ((acc_kind == ACC_READ) || (acc_kind == ACC_WRITE)) && overlap;
        endcase
    end

    // Final qualification by valid and arming.
    always_comb hit = acc_valid && armed && type_hit;
endmodule

// File: rtl/dbg_bp_regs.sv
`timescale 1ns/1ps
// Module: software-visible registers of the breakpoint unit.
// Holds the slot addresses, the raw control word and the sticky status.
// Blocks every register access while general-detect is set and turns the
// blocked access into a trap. Assumes ADDR_W >= 32.
module dbg_bp_regs
    import dbg_bp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic                          reg_rd,
    input  logic [SEL_W-1:0]              reg_sel,
    input  logic [ADDR_W-1:0]             reg_wdata,
    output logic [ADDR_W-1:0]             reg_rdata,
    input  logic [SLOTS-1:0]              hit_now,
    input  logic                          step_evt,
    input  logic                          task_evt,
    output logic [SLOTS-1:0][ADDR_W-1:0]  slot_addr,
    output logic [SLOTS*TYPE_W-1:0]       slot_types,
    output logic [SLOTS*LEN_W-1:0]        slot_lens,
    output logic [SLOTS-1:0]              armed,
    output logic                          gd_q,
    output logic                          gd_trap,
    output logic                          sts_wr_ok,
    output logic [STS_W-1:0]              status_q
);
    logic [ADDR_W-1:0] ctl_q;
    logic              acc_ok;
    logic [STS_W-1:0]  sts_set;

    // Decode the control word into per-slot fields.
    always_comb begin
        gd_q       = ctl_q[CTL_GD_BIT];
        armed      = ctl_q[SLOTS-1:0] | ctl_q[CTL_GLB_LO +: SLOTS];
        slot_types = ctl_q[CTL_TYPE_LO +: SLOTS*TYPE_W];
        slot_lens  = ctl_q[CTL_LEN_LO +: SLOTS*LEN_W];
    end

    // Trap detection and access gating.
    always_comb begin
        gd_trap   = gd_q && (reg_wr || reg_rd);
        acc_ok    = !gd_trap;
        sts_wr_ok = reg_wr && acc_ok && (reg_sel == SEL_STATUS);
    end

    // Status bits raised this cycle.
    always_comb begin
        sts_set         = '0;
        sts_set[SLOTS-1:0] = hit_now;
        sts_set[STS_BD] = gd_trap;
        sts_set[STS_BS] = step_evt;
        sts_set[STS_BT] = task_evt;
    end

    // Slot address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_addr <= '0;
        end else if (reg_wr && acc_ok && (reg_sel < SEL_W'(SLOTS))) begin
            slot_addr[reg_sel[1:0]] <= reg_wdata;
        end
    end

    // Control word; a trap clears general-detect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (gd_trap) begin
            ctl_q[CTL_GD_BIT] <= 1'b0;
        end else if (reg_wr && (reg_sel == SEL_CONTROL)) begin
            ctl_q <= reg_wdata;
        end
    end

    // Sticky status; a write replaces, new events are ORed on top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (sts_wr_ok ? reg_wdata[STS_W-1:0] : status_q) | sts_set;
        end
    end

    // Read mux; zero when idle or blocked.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd && acc_ok) begin
            if (reg_sel < SEL_W'(SLOTS)) begin
                reg_rdata = slot_addr[reg_sel[1:0]];
            end else if (reg_sel == SEL_STATUS) begin
                reg_rdata = ADDR_W'(status_q);
            end else if (reg_sel == SEL_CONTROL) begin
                reg_rdata = ctl_q;
            end
        end
    end
endmodule

// File: rtl/dbg_bp_report.sv
`timescale 1ns/1ps
// Module: registered result stage.
// Turns the combinational slot hits and the trap into one-cycle outputs.
// Assumes its inputs are valid for one cycle per event.
module dbg_bp_report
    import dbg_bp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] hit_now,
    input  logic [SLOTS-1:0] insn_now,
    input  logic             gd_trap,
    output logic [SLOTS-1:0] hit_vec,
    output logic             dbg_req,
    output logic             dbg_req_insn
);
    // Register the hits and build the request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_vec      <= '0;
            dbg_req      <= 1'b0;
            dbg_req_insn <= 1'b0;
        end else begin
            hit_vec      <= hit_now;
            dbg_req      <= (|hit_now) || gd_trap;
            dbg_req_insn <= |insn_now;
        end
    end
endmodule

// File: rtl/dbg_bp_matcher.sv
`timescale 1ns/1ps
// Module: top of the debug breakpoint address matcher.
// Instantiates the register block, one comparator per slot and the result
// stage. Synchronous active-low reset. Assumes ADDR_W >= 32.
module dbg_bp_matcher
    import dbg_bp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [SEL_W-1:0]   reg_sel,
    input  logic [ADDR_W-1:0]  reg_wdata,
    output logic [ADDR_W-1:0]  reg_rdata,
    input  logic               io_ext_en,
    input  logic               step_evt,
    input  logic               task_evt,
    input  logic               acc_valid,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [NBYTE_W-1:0] acc_bytes,
    input  logic [1:0]         acc_kind,
    output logic [SLOTS-1:0]   hit_vec,
    output logic               dbg_req,
    output logic               dbg_req_insn
);
    logic [SLOTS-1:0][ADDR_W-1:0] slot_addr;
    logic [SLOTS*TYPE_W-1:0]      slot_types;
    logic [SLOTS*LEN_W-1:0]       slot_lens;
    logic [SLOTS-1:0]             armed_w;
    logic                         gd_q;
    logic                         gd_trap;
    logic                         sts_wr_ok;
    logic [STS_W-1:0]             status_q;
    logic [SLOTS-1:0]             hit_now;
    logic [SLOTS-1:0]             insn_now;

    dbg_bp_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .hit_now    (hit_now),
        .step_evt   (step_evt),
        .task_evt   (task_evt),
        .slot_addr  (slot_addr),
        .slot_types (slot_types),
        .slot_lens  (slot_lens),
        .armed      (armed_w),
        .gd_q       (gd_q),
        .gd_trap    (gd_trap),
        .sts_wr_ok  (sts_wr_ok),
        .status_q   (status_q)
    );

    // One comparator per slot plus its instruction-type qualifier.
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        dbg_bp_slot #(.ADDR_W(ADDR_W)) u_slot (
            .bp_addr   (slot_addr[i]),
            .bp_type   (slot_types[i*TYPE_W +: TYPE_W]),
            .bp_len    (slot_lens[i*LEN_W +: LEN_W]),
            .armed     (armed_w[i]),
            .io_ext_en (io_ext_en),
            .acc_valid (acc_valid),
            .acc_addr  (acc_addr),
            .acc_bytes (acc_bytes),
            .acc_kind  (acc_kind),
            .hit       (hit_now[i])
        );
        assign insn_now[i] = hit_now[i] && (slot_types[i*TYPE_W +: TYPE_W] == BPT_EXEC);
    end

    dbg_bp_report u_report (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit_now      (hit_now),
        .insn_now     (insn_now),
        .gd_trap      (gd_trap),
        .hit_vec      (hit_vec),
        .dbg_req      (dbg_req),
        .dbg_req_insn (dbg_req_insn)
    );
endmodule

// File: rtl/dbg_bp_checker.sv
`timescale 1ns/1ps
// Module: temporal checks for dbg_bp_matcher, attached with bind.
module dbg_bp_checker
    import dbg_bp_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic [SLOTS-1:0]        hit_vec,
    input logic                    dbg_req,
    input logic                    dbg_req_insn,
    input logic [SLOTS-1:0]        armed,
    input logic [SLOTS*TYPE_W-1:0] slot_types,
    input logic                    io_ext_en,
    input logic [STS_W-1:0]        status_q,
    input logic                    sts_wr_ok,
    input logic                    gd_q,
    input logic                    gd_trap
);
    for (genvar i = 0; i < SLOTS; i++) begin : g_chk
        p_hit_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
            hit_vec[i] |-> $past(armed[i]));
        p_io_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_vec[i] && ($past(slot_types[i*TYPE_W +: TYPE_W]) == 2'b10)) |-> $past(io_ext_en));
    end

    p_hit_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_vec) |-> ((status_q[SLOTS-1:0] & hit_vec) == hit_vec));

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sts_wr_ok) |-> ((status_q & $past(status_q)) == $past(status_q)));

    p_req_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |-> ((hit_vec != '0) || $past(gd_trap)));

    p_insn_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req_insn |-> (dbg_req && (hit_vec != '0)));

    p_gd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gd_trap) |-> (!gd_q && status_q[STS_BD] && dbg_req));
endmodule

bind dbg_bp_matcher dbg_bp_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit_vec      (hit_vec),
    .dbg_req      (dbg_req),
    .dbg_req_insn (dbg_req_insn),
    .armed        (armed_w),
    .slot_types   (slot_types),
    .io_ext_en    (io_ext_en),
    .status_q     (status_q),
    .sts_wr_ok    (sts_wr_ok),
    .gd_q         (gd_q),
    .gd_trap      (gd_trap)
);

// File: tb/dbg_bp_matcher_tb_top.sv
`timescale 1ns/1ps
// Directed bench for dbg_bp_matcher: one task per scenario.
module dbg_bp_matcher_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        io_ext_en = 1'b0;
    logic        step_evt = 1'b0;
    logic        task_evt = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [3:0]  acc_bytes = 4'd1;
    logic [1:0]  acc_kind = '0;
    logic [3:0]  hit_vec;
    logic        dbg_req;
    logic        dbg_req_insn;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    localparam logic [1:0] K_FETCH = 2'b00, K_READ = 2'b01, K_WRITE = 2'b10, K_IO = 2'b11;

    always #5 clk = ~clk;

    dbg_bp_matcher #(.ADDR_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .io_ext_en(io_ext_en), .step_evt(step_evt), .task_evt(task_evt),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_bytes(acc_bytes),
        .acc_kind(acc_kind), .hit_vec(hit_vec), .dbg_req(dbg_req),
        .dbg_req_insn(dbg_req_insn)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctl(input logic [3:0] loc, input logic [3:0] glb,
        input logic gd, input logic [1:0] t0, t1, t2, t3, l0, l1, l2, l3);
        return {l3, l2, l1, l0, t3, t2, t1, t0, 7'b0, gd, glb, loc};
    endfunction

    task automatic wr_reg(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] s, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_sel = s;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic access(input string tag, input logic [31:0] a, input logic [3:0] n,
                          input logic [1:0] k, input logic [3:0] exp_hit, input logic exp_insn);
        @(negedge clk); acc_valid = 1'b1; acc_addr = a; acc_bytes = n; acc_kind = k;
        @(negedge clk); acc_valid = 1'b0;
        chk({tag, " hit_vec"}, 32'(hit_vec), 32'(exp_hit));
        chk({tag, " dbg_req"}, 32'(dbg_req), 32'(exp_hit != 4'd0));
        chk({tag, " insn"}, 32'(dbg_req_insn), 32'(exp_insn));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R12 hit_vec after reset", 32'(hit_vec), 0);
        chk("R12 dbg_req after reset", 32'(dbg_req), 0);
        rd_reg(3'd5, d); chk("R12 control after reset", d, 0);
        rd_reg(3'd4, d); chk("R12 status after reset", d, 0);
        rd_reg(3'd0, d); chk("R12 addr0 after reset", d, 0);
        access("R12 no hit after reset", 32'h0, 4'd1, K_READ, 4'b0000, 1'b0);
    endtask

    task automatic t_disarmed();
        wr_reg(3'd0, 32'h1000);
        wr_reg(3'd5, mk_ctl(4'b0000, 4'b0000, 1'b0, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00));
        access("R6 disarmed slot", 32'h1000, 4'd1, K_READ, 4'b0000, 1'b0);
    endtask

    task automatic t_write_bp();
        wr_reg(3'd0, 32'h1003);
        wr_reg(3'd5, mk_ctl(4'b0001, 4'b0000, 1'b0, 2'b01, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00));
        access("R1 R3 write inside aligned range", 32'h1002, 4'd1, K_WRITE, 4'b0001, 1'b0);
        @(negedge clk);
        chk("R7 dbg_req is one cycle", 32'(dbg_req), 0);
        chk("R7 hit_vec is one cycle", 32'(hit_vec), 0);
        access("R1 read ignored by write-only", 32'h1002, 4'd1, K_READ, 4'b0000, 1'b0);
        access("R4 write just below range", 32'h0FFE, 4'd2, K_WRITE, 4'b0000, 1'b0);
        access("R4 write straddling low edge", 32'h0FFF, 4'd2, K_WRITE, 4'b0001, 1'b0);
        access("R3 write just above range", 32'h1004, 4'd4, K_WRITE, 4'b0000, 1'b0);
    endtask

    task automatic t_rdwr_bp();
        wr_reg(3'd1, 32'h2005);
        wr_reg(3'd5, mk_ctl(4'b0000, 4'b0010, 1'b0, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 2'b00));
        access("R1 R6 read via global enable", 32'h2007, 4'd1, K_READ, 4'b0010, 1'b0);
        access("R3 8-byte range aligned low", 32'h2000, 4'd1, K_WRITE, 4'b0010, 1'b0);
        access("R3 past 8-byte range", 32'h2008, 4'd1, K_READ, 4'b0000, 1'b0);
        access("R1 fetch ignored by data type", 32'h2000, 4'd1, K_FETCH, 4'b0000, 1'b0);
        access("R1 io ignored by data type", 32'h2000, 4'd1, K_IO, 4'b0000, 1'b0);
    endtask

    task automatic t_insn_bp();
        wr_reg(3'd2, 32'h3000);
        wr_reg(3'd5, mk_ctl(4'b0100, 4'b0000, 1'b0, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00));
        access("R5 R8 fetch at slot address", 32'h3000, 4'd4, K_FETCH, 4'b0100, 1'b1);
        access("R5 fetch covering but not starting", 32'h2FFE, 4'd4, K_FETCH, 4'b0000, 1'b0);
        access("R5 length code ignored for fetch", 32'h3001, 4'd1, K_FETCH, 4'b0000, 1'b0);
        access("R5 data read at exec slot", 32'h3000, 4'd1, K_READ, 4'b0000, 1'b0);
    endtask

    task automatic t_io_bp();
        wr_reg(3'd3, 32'h61);
        wr_reg(3'd5, mk_ctl(4'b1000, 4'b0000, 1'b0, 2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 2'b01));
        io_ext_en = 1'b0;
        access("R2 io type undefined when disabled", 32'h60, 4'd1, K_IO, 4'b0000, 1'b0);
        io_ext_en = 1'b1;
        access("R2 io hit when enabled", 32'h60, 4'd1, K_IO, 4'b1000, 1'b0);
        access("R2 R4 io straddling low edge", 32'h5F, 4'd2, K_IO, 4'b1000, 1'b0);
        access("R2 data read at io slot", 32'h60, 4'd1, K_READ, 4'b0000, 1'b0);
        io_ext_en = 1'b0;
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        wr_reg(3'd4, 32'h0);
        wr_reg(3'd0, 32'h4000);
        wr_reg(3'd1, 32'h4002);
        wr_reg(3'd5, mk_ctl(4'b0001, 4'b0010, 1'b0, 2'b11, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00));
        access("R9 two slots in one access", 32'h4002, 4'd1, K_WRITE, 4'b0011, 1'b0);
        rd_reg(3'd4, d); chk("R9 both detect bits", d, 32'h3);
        access("R9 single slot", 32'h4000, 4'd1, K_READ, 4'b0001, 1'b0);
        access("R9 miss", 32'h5000, 4'd1, K_READ, 4'b0000, 1'b0);
        rd_reg(3'd4, d); chk("R9 bits stay set", d, 32'h3);
        wr_reg(3'd4, 32'h0);
        rd_reg(3'd4, d); chk("R9 cleared by status write", d, 32'h0);
    endtask

    task automatic t_gd();
        logic [31:0] d;
        wr_reg(3'd5, 32'h0000_0100);
        rd_reg(3'd0, d);
        chk("R10 blocked read returns zero", d, 0);
        chk("R10 trap raises request", 32'(dbg_req), 1);
        chk("R10 trap has no slot hit", 32'(hit_vec), 0);
        rd_reg(3'd4, d); chk("R10 access-detect bit", d, 32'h10);
        rd_reg(3'd5, d); chk("R10 general-detect cleared", d, 0);
        wr_reg(3'd5, 32'h0000_0100);
        wr_reg(3'd0, 32'hDEAD);
        chk("R10 blocked write raises request", 32'(dbg_req), 1);
        rd_reg(3'd0, d); chk("R10 blocked write ignored", d, 32'h4000);
    endtask

    task automatic t_events();
        logic [31:0] d;
        wr_reg(3'd5, 32'h0);
        wr_reg(3'd4, 32'h0);
        @(negedge clk); step_evt = 1'b1;
        @(negedge clk); step_evt = 1'b0;
        chk("R11 step gives no request", 32'(dbg_req), 0);
        rd_reg(3'd4, d); chk("R11 single-step bit", d, 32'h20);
        @(negedge clk); task_evt = 1'b1;
        @(negedge clk); task_evt = 1'b0;
        rd_reg(3'd4, d); chk("R11 task-switch bit", d, 32'h60);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disarmed();
        t_write_bp();
        t_rdwr_bp();
        t_insn_bp();
        t_io_bp();
        t_sticky();
        t_gd();
        t_events();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule